// File: doc/BRIEF.md
# Incremental-phase carrier rotator

This block produces the cosine/sine carrier stream used by one tracking channel. The carrier phase advances by a fixed small angle every sample. Because of that, the block does not rotate from zero on each sample. It keeps the current carrier vector in a register and, for every accepted sample, rotates that vector by the fixed step through a chain of shift-and-add micro-rotation stages. A constant gain correction follows the chain. No general multipliers are used in the rotation, and large-angle stages are left out of the chain.

When a new phase step is loaded, a short search walks a residual angle through an arctangent table. This fixes one rotation direction per stage, and those directions are then reused for every sample until the next load. A separate re-seed strobe replaces only the carrier vector, for example at the start of each integration period, so that drift from repeated rotations stays bounded. The block can accept one sample per clock, and each output leaves a fixed two-cycle pipeline with its valid flag.

Top module: `cinc_carrier_nco`

## Requirements
- R1: While reset is high and after it, before any load, `busy_o` and `valid_o` are 0 and `cos_o`/`sin_o` are 0.
- R2: A cycle with `load_i` high raises `busy_o` at the next clock edge. `busy_o` then stays high for exactly 9 clock cycles, one per stage (stages i = 3..11). A load during busy restarts the count.
- R3: The step is signed radians with 16 fraction bits, with |step| at most 0.24 rad. Stage i rotates by +atan(2^-i) when the residual is at or above zero, and otherwise by -atan(2^-i). The residual starts at the step and moves by the stage's table value, which is atan(2^-i)·2^16 rounded. The angle per sample is the sum of these signed rotations.
- R4: `adv_i` is ignored while `busy_o` is high and in any cycle with `load_i` or `reseed_i` high. Such an `adv_i` produces no output and does not advance the carrier.
- R5: Each accepted `adv_i` gives exactly one `valid_o` pulse, two clock edges after the edge that sampled it. `valid_o` is low at all other times.
- R6: The first output after a load or re-seed equals the seed vector exactly.
- R7: The n-th output after a seed (n counted from 0, n < 48, seed magnitude at most 2000) is the seed rotated by n times the angle of R3, within ±3 LSB on each component.
- R8: `reseed_i` replaces the carrier vector without raising `busy_o` and keeps the current directions.
- R9: Gaps between accepted samples do not change the sequence. Output n depends only on the number of accepted samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Capture a new step and seed vector, and start the direction search |
| reseed_i | input | 1 | Capture a new seed vector only |
| step_i | input | 18 | Signed phase step per sample, radians with 16 fraction bits |
| seed_cos_i | input | 12 | Signed seed cosine component |
| seed_sin_i | input | 12 | Signed seed sine component |
| adv_i | input | 1 | Sample request: emit the current vector and advance it |
| busy_o | output | 1 | Direction search in progress |
| valid_o | output | 1 | Output sample valid |
| cos_o | output | 12 | Signed cosine output |
| sin_o | output | 12 | Signed sine output |

## Verification
`busy_o` is due one edge after a load and must fall exactly nine edges later. The bench drives `load_i` and `adv_i` at falling edges and counts busy cycles at falling edges. Outputs of an accepted request are due after the second rising edge, so at every falling edge the bench compares `valid_o` with the request it drove two falling edges earlier. It scores a sample only in the cycle where that comparison says a sample is due, so continuous, alternating and irregular request patterns are all checked against the same arithmetic rotation of the seed.

// File: rtl/cinc_pkg.sv
package cinc_pkg;

    localparam int OUT_W       = 12;
    localparam int GUARD_W     = 6;
    localparam int INT_W       = OUT_W + GUARD_W + 1;
    localparam int FIRST_STAGE = 3;
    localparam int LAST_STAGE  = OUT_W - 1;
    localparam int N_STAGES    = LAST_STAGE - FIRST_STAGE + 1;
    localparam int ANG_FRAC    = 16;
    localparam int ANG_W       = ANG_FRAC + 2;
    localparam int GAIN_FRAC   = INT_W + 2;
    localparam int IDX_W       = $clog2(N_STAGES + 1);
    localparam int ACC_FRAC    = 60;

    typedef logic signed [INT_W-1:0] coord_t;
    typedef logic signed [OUT_W-1:0] out_t;
    typedef logic signed [ANG_W-1:0] ang_t;
    typedef logic [N_STAGES-1:0]     dir_t;
    typedef logic [N_STAGES-1:0][ANG_W-1:0] atan_tab_t;

    typedef struct packed {
        coord_t re;
        coord_t im;
    } vec_t;

    typedef struct packed {
        out_t c;
        out_t s;
    } sample_t;

    // atan(2^-i) scaled by 2^frac, via the odd power series, rounded
    function automatic longint atan_q(int i, int frac);
        longint acc;
        acc = 0;
        for (int k = 0; k < 16; k++) begin
            int e;
            longint term;
            e = ACC_FRAC - i * (2 * k + 1);
            if (e > 0) begin
                term = (longint'(1) <<< e) / longint'(2 * k + 1);
                if ((k % 2) == 0) acc = acc + term;
                else              acc = acc - term;
            end
        end
        return (acc + (longint'(1) <<< (ACC_FRAC - frac - 1))) >>> (ACC_FRAC - frac);
    endfunction

    function automatic atan_tab_t build_atan_tab();
        atan_tab_t t;
        for (int j = 0; j < N_STAGES; j++)
            t[j] = ANG_W'(atan_q(FIRST_STAGE + j, ANG_FRAC));
        return t;
    endfunction

    // reciprocal of the chain gain, product of (1+2^-2i)^-1/2 over active stages
    function automatic longint inv_gain_q();
        longint g;
        g = longint'(1) <<< 40;
        for (int i = FIRST_STAGE; i <= LAST_STAGE; i++)
            g = g - (g >>> (2 * i + 1)) + ((g * 3) >>> (4 * i + 3));
        return (g + (longint'(1) <<< (40 - GAIN_FRAC - 1))) >>> (40 - GAIN_FRAC);
    endfunction

    // arithmetic right shift with round-half-up
    function automatic coord_t rshr(coord_t v, int sh);
        return (v + (coord_t'(1) <<< (sh - 1))) >>> sh;
    endfunction

endpackage

// File: rtl/cinc_dir_search.sv
module cinc_dir_search
    import cinc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  ang_t step,
    output dir_t dir,
    output logic busy
);

    localparam atan_tab_t TAB = build_atan_tab();

    ang_t             resid;
    logic [IDX_W-1:0] idx;
    ang_t             tab_now;

    assign tab_now = ang_t'(TAB[idx]);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            idx   <= '0;
            resid <= '0;
            dir   <= '0;
        end else if (load) begin
            busy  <= 1'b1;
            idx   <= '0;
            resid <= step;
            dir   <= '0;
        end else if (busy) begin
            dir[idx] <= ~resid[ANG_W-1];
            resid    <= resid[ANG_W-1] ? (resid + tab_now) : (resid - tab_now);
            if (idx == IDX_W'(N_STAGES - 1)) begin
                busy <= 1'b0;
                idx  <= '0;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end

endmodule

// File: rtl/cinc_rotator.sv
module cinc_rotator
    import cinc_pkg::*;
(
    input  vec_t vin,
    input  dir_t dir,
    output vec_t vout
);

    localparam int PW = INT_W + GAIN_FRAC + 2;
    localparam logic signed [GAIN_FRAC+1:0] GAIN = (GAIN_FRAC + 2)'(inv_gain_q());

    coord_t cre [N_STAGES+1];
    coord_t cim [N_STAGES+1];

    assign cre[0] = vin.re;
    assign cim[0] = vin.im;

    generate
        for (genvar j = 0; j < N_STAGES; j++) begin : g_stage
            localparam int SH = FIRST_STAGE + j;
            coord_t xs;
            coord_t ys;
            assign xs = rshr(cre[j], SH);
            assign ys = rshr(cim[j], SH);
            assign cre[j+1] = dir[j] ? (cre[j] - ys) : (cre[j] + ys);
            assign cim[j+1] = dir[j] ? (cim[j] + xs) : (cim[j] - xs);
        end
    endgenerate

    logic signed [PW-1:0] pre;
    logic signed [PW-1:0] pim;
    logic signed [PW-1:0] rre;
    logic signed [PW-1:0] rim;

    assign pre = PW'(cre[N_STAGES]) * PW'(GAIN);
    assign pim = PW'(cim[N_STAGES]) * PW'(GAIN);
    assign rre = (pre + (PW'(1) <<< (GAIN_FRAC - 1))) >>> GAIN_FRAC;
    assign rim = (pim + (PW'(1) <<< (GAIN_FRAC - 1))) >>> GAIN_FRAC;

    assign vout.re = coord_t'(rre);
    assign vout.im = coord_t'(rim);

endmodule

// File: rtl/cinc_out_stage.sv
module cinc_out_stage
    import cinc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    accept,
    input  vec_t    cur,
    output sample_t smp,
    output logic    valid
);

    vec_t held;
    logic held_v;

    always_ff @(posedge clk) begin
        if (rst) begin
            held   <= '0;
            held_v <= 1'b0;
            smp    <= '0;
            valid  <= 1'b0;
        end else begin
            held_v <= accept;
            if (accept) held <= cur;
            valid <= held_v;
            if (held_v) begin
                smp.c <= out_t'(rshr(held.re, GUARD_W));
                smp.s <= out_t'(rshr(held.im, GUARD_W));
            end
        end
    end

endmodule

// File: rtl/cinc_carrier_nco.sv
module cinc_carrier_nco
    import cinc_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load_i,
    input  logic                    reseed_i,
    input  logic signed [ANG_W-1:0] step_i,
    input  logic signed [OUT_W-1:0] seed_cos_i,
    input  logic signed [OUT_W-1:0] seed_sin_i,
    input  logic                    adv_i,
    output logic                    busy_o,
    output logic                    valid_o,
    output logic signed [OUT_W-1:0] cos_o,
    output logic signed [OUT_W-1:0] sin_o
);

    dir_t    dir;
    logic    busy;
    logic    accept;
    vec_t    state;
    vec_t    nxt;
    sample_t smp;

    assign accept = adv_i & ~busy & ~load_i & ~reseed_i;

    cinc_dir_search u_search (
        .clk  (clk),
        .rst  (rst),
        .load (load_i),
        .step (step_i),
        .dir  (dir),
        .busy (busy)
    );

    cinc_rotator u_rot (
        .vin  (state),
        .dir  (dir),
        .vout (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= '0;
        end else if (load_i || reseed_i) begin
            state.re <= coord_t'(seed_cos_i) <<< GUARD_W;
            state.im <= coord_t'(seed_sin_i) <<< GUARD_W;
        end else if (accept) begin
            state <= nxt;
        end
    end

    cinc_out_stage u_out (
        .clk    (clk),
        .rst    (rst),
        .accept (accept),
        .cur    (state),
        .smp    (smp),
        .valid  (valid_o)
    );

    assign busy_o = busy;
    assign cos_o  = smp.c;
    assign sin_o  = smp.s;

endmodule

// File: rtl/cinc_checker.sv
module cinc_checker
    import cinc_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic load,
    input logic accept,
    input logic busy,
    input logic valid
);

    logic [IDX_W:0] run;

    always_ff @(posedge clk) begin
        if (rst)       run <= '0;
        else if (load) run <= '0;
        else if (busy) run <= run + 1'b1;
    end

    assert_load_busy_R2: assert property (@(posedge clk) disable iff (rst)
        load |=> busy) else $error("load did not raise busy");

    assert_busy_len_R2: assert property (@(posedge clk) disable iff (rst)
        busy |-> (run < (IDX_W + 1)'(N_STAGES))) else $error("busy too long");

    assert_busy_end_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (run == (IDX_W + 1)'(N_STAGES))) else $error("busy ended early");

    assert_busy_blocks_R4: assert property (@(posedge clk) disable iff (rst)
        busy |=> ##1 !valid) else $error("output from a blocked request");

    assert_latency_R5: assert property (@(posedge clk) disable iff (rst)
        accept |=> ##1 valid) else $error("missing output");

    assert_no_spurious_R5: assert property (@(posedge clk) disable iff (rst)
        !accept |=> ##1 !valid) else $error("spurious output");

endmodule

bind cinc_carrier_nco cinc_checker u_chk (
    .clk    (clk),
    .rst    (rst),
    .load   (load_i),
    .accept (accept),
    .busy   (busy_o),
    .valid  (valid_o)
);

// File: tb/tb_cinc_carrier_nco.sv
module tb_cinc_carrier_nco;
    import cinc_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic load_i = 1'b0;
    logic reseed_i = 1'b0;
    logic adv_i = 1'b0;
    logic signed [ANG_W-1:0] step_i = '0;
    logic signed [OUT_W-1:0] seed_cos_i = '0;
    logic signed [OUT_W-1:0] seed_sin_i = '0;
    logic busy_o, valid_o;
    logic signed [OUT_W-1:0] cos_o, sin_o;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    real theta = 0.0;
    int cur_c = 0;
    int cur_s = 0;

    always #5 clk = ~clk;

    cinc_carrier_nco dut (
        .clk(clk), .rst(rst), .load_i(load_i), .reseed_i(reseed_i),
        .step_i(step_i), .seed_cos_i(seed_cos_i), .seed_sin_i(seed_sin_i),
        .adv_i(adv_i), .busy_o(busy_o), .valid_o(valid_o),
        .cos_o(cos_o), .sin_o(sin_o)
    );

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // R3: greedy residual decisions on the rounded table, exact angles summed
    function automatic real eff_angle(int step);
        int  z = step;
        real th = 0.0;
        for (int i = FIRST_STAGE; i <= LAST_STAGE; i++) begin
            real a = $atan(2.0 ** (-i));
            int  aq = $rtoi(a * 65536.0 + 0.5);
            if (z >= 0) begin th = th + a; z = z - aq; end
            else        begin th = th - a; z = z + aq; end
        end
        return th;
    endfunction

    task automatic do_load(int step, int c, int s);
        int cnt = 0;
        @(negedge clk);
        load_i = 1'b1; step_i = ANG_W'(step);
        seed_cos_i = OUT_W'(c); seed_sin_i = OUT_W'(s);
        adv_i = 1'b1;                                  // R4: ignored in load cycle
        @(negedge clk);
        load_i = 1'b0;
        chk(busy_o == 1'b1, "R2", "busy after load", busy_o, 1);
        while (busy_o && cnt < 100) begin
            chk(valid_o == 1'b0, "R4", "valid while busy", valid_o, 0);
            cnt++;
            @(negedge clk);
        end
        adv_i = 1'b0;
        chk(cnt == N_STAGES, "R2", "busy cycles", cnt, N_STAGES);
        cur_c = c; cur_s = s;
        theta = eff_angle(step);
    endtask

    task automatic do_reseed(int c, int s);
        @(negedge clk);
        reseed_i = 1'b1; seed_cos_i = OUT_W'(c); seed_sin_i = OUT_W'(s);
        adv_i = 1'b1;                                  // R4: ignored in re-seed cycle
        @(negedge clk);
        reseed_i = 1'b0; adv_i = 1'b0;
        chk(busy_o == 1'b0, "R8", "busy after reseed", busy_o, 0);
        cur_c = c; cur_s = s;
    endtask

    function automatic bit pattern(int mode, int t);
        if (mode == 0) return 1'b1;
        if (mode == 1) return (t % 2) == 0;
        return ((t * 7) % 5) < 2;
    endfunction

    task automatic run_seq(int nsamp, int mode);
        int sent = 0;
        int got = 0;
        int t = 0;
        bit a1 = 0;
        bit a2 = 0;
        string rq;
        rq = (mode == 0) ? "R7" : "R9";
        while (got < nsamp && t < 10000) begin
            chk(valid_o == a2, "R5", "valid timing", valid_o, a2);
            if (valid_o) begin
                real ec = cur_c * $cos(got * theta) - cur_s * $sin(got * theta);
                real es = cur_c * $sin(got * theta) + cur_s * $cos(got * theta);
                int ac = cos_o;
                int as_ = sin_o;
                if (got == 0) begin
                    chk(ac == cur_c, "R6", "first cos", ac, cur_c);
                    chk(as_ == cur_s, "R6", "first sin", as_, cur_s);
                end else begin
                    chk((ac - ec) <= 3.0 && (ec - ac) <= 3.0, rq, "cos", ac, $rtoi(ec));
                    chk((as_ - es) <= 3.0 && (es - as_) <= 3.0, rq, "sin", as_, $rtoi(es));
                end
                got++;
            end
            a2 = a1;
            a1 = (sent < nsamp) && pattern(mode, t);
            adv_i = a1;
            if (a1) sent++;
            t++;
            @(negedge clk);
        end
        adv_i = 1'b0;
        chk(got == nsamp, "R5", "sample count", got, nsamp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(busy_o == 1'b0, "R1", "reset busy", busy_o, 0);
        chk(valid_o == 1'b0, "R1", "reset valid", valid_o, 0);
        chk(cos_o == 0, "R1", "reset cos", cos_o, 0);
        chk(sin_o == 0, "R1", "reset sin", sin_o, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(valid_o == 1'b0 && busy_o == 1'b0, "R1", "idle after reset", valid_o, 0);

        do_load(4500, 2000, 0);       run_seq(48, 0);
        do_reseed(0, -1500);          run_seq(40, 1);
        do_load(-9000, 1200, 1500);   run_seq(48, 2);
        do_load(15700, -1800, 600);   run_seq(40, 0);
        do_load(0, 1000, -1000);      run_seq(32, 0);
        do_load(-15700, 0, 2000);     run_seq(48, 1);

        // R2: a load during the search restarts it
        @(negedge clk);
        load_i = 1'b1; step_i = ANG_W'(3000);
        @(negedge clk);
        load_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        do_load(7000, 1700, -900);    run_seq(24, 0);
        do_reseed(-1300, -1300);      run_seq(30, 2);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule